// File: doc/BRIEF.md
# DMA Controller CPU Register Port

This block is the processor-facing side of a four-channel DMA controller. The host drives an active-low chip select, a 4-bit register address and active-low read and write strobes. The block turns each strobe into exactly one 8-bit register access. The 16-bit per-channel address and word-count registers are held in the sequencer. This block gives the sequencer per-channel write enables, a byte select and write data for those registers. It reads their current values back one byte at a time. A byte pointer flip-flop chooses the byte: low byte first, flipping after every access to one of those registers.

The block itself holds the command, mask, software request and per-channel mode registers, plus the terminal-count half of the status register. Four addresses are commands that act on the address decode alone and ignore the data bus: clear pointer, set pointer, master clear and clear all masks. A read of address 14 rewinds the mode readback counter. Accesses are honoured only while the controller is in its program condition: chip select low and hold acknowledge low. This includes the window after a hold request has been raised but not yet acknowledged.

Top module: `dma_prog_port`

## Requirements
- R1: An access takes effect only when cs_ni=0 and hold_ack_i=0. Otherwise no write enable or mclr_o pulse appears, and the cmd_o, mask_o, req_o and mode_o outputs and the byte pointer are unchanged.
- R2: An access is started by a 1-to-0 transition of iow_ni (write) or ior_ni (read), as sampled on clock rising edges. A strobe held low for several cycles counts as one access.
- R3: Addresses 0 to 7 select a channel register. The channel is addr[2:1]. addr[0]=0 is the address register and addr[0]=1 is the count register. A write pulses addr_we_o[ch] or cnt_we_o[ch] for one cycle, with wdata_o = data_i and byte_hi_o equal to the byte pointer before the access.
- R4: The byte pointer is 0 after reset. It flips after every read or write of addresses 0 to 7, and no other access flips it.
- R5: A write to address 12 clears the byte pointer and a write to address 13 sets it, whatever the data.
- R6: A read of addresses 0 to 7 returns, on data_o, byte [7:0] (pointer 0) or byte [15:8] (pointer 1) of the channel's cur_addr_i or cur_cnt_i slice (channel c at bits 16c+15:16c). The value holds until the next read.
- R7: A write to address 8 loads cmd_o. A read of address 8 returns {dreq_i, tc[3:0]}. tc bit c is set by tc_i[c] and held. A status read clears the tc bits, except that a bit set in the same cycle stays set.
- R8: Writes to addresses 9 and 10 use data[1:0] as the channel and data[2] as the new value of that channel's request bit (9) or mask bit (10). Reads return {4'b0, req_o} and {4'b0, mask_o}.
- R9: A write to address 11 loads data[7:2] as the mode of channel data[1:0] (mode_o bits 6c+5:6c). A read of address 11 returns {mode, channel} for the channel given by a 2-bit readback counter, which then advances modulo 4. A read of address 14 clears the counter.
- R10: A write to address 14, whatever the data, is a master clear. It sets mask to 4'b1111, clears command, request, tc bits, byte pointer and mode counter, keeps the modes, and pulses mclr_o for one cycle.
- R11: A write to address 15, whatever the data, clears all four mask bits.
- R12: After reset: cmd_o=0, mask_o=4'hF, req_o=0, mode_o=0, tc bits 0, data_o=0, and no enables or pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ior_ni | input | 1 | Read strobe, active low |
| iow_ni | input | 1 | Write strobe, active low |
| hold_ack_i | input | 1 | Bus hold acknowledge from the processor |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Write data bus |
| cur_addr_i | input | 64 | Current address of each channel, 16 bits per channel |
| cur_cnt_i | input | 64 | Current word count of each channel, 16 bits per channel |
| tc_i | input | 4 | Terminal-count event per channel from the sequencer |
| dreq_i | input | 4 | Request lines, shown in the status register |
| data_o | output | 8 | Read data, latched on each read |
| addr_we_o | output | 4 | One-cycle write enable per channel address register |
| cnt_we_o | output | 4 | One-cycle write enable per channel count register |
| byte_hi_o | output | 1 | Byte select for the enabled write: 1 = upper byte |
| wdata_o | output | 8 | Byte to write into the enabled register |
| cmd_o | output | 8 | Command register |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| mode_o | output | 24 | Mode of each channel, 6 bits per channel |
| mclr_o | output | 1 | One-cycle master clear pulse |

## Verification
The first rising edge that samples a strobe low is the access edge. Write enables, byte select, write data, mclr_o, register updates, the pointer flip, the tc clear and the latched read data all appear right after that edge, so one cycle after the strobe is driven. The bench drives every input on a falling edge and samples results on the next falling edge. Each result is therefore read half a cycle after the register that produced it has updated. Checks that span a held strobe count enable pulses on each later falling edge. Checks on ignored accesses look at the register outputs and at the byte select of the next honoured access.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
  localparam int NUM_CH   = 4;
  localparam int CH_W     = $clog2(NUM_CH);
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int MODE_W   = BYTE_W - CH_W;
  localparam int ADDR_W   = 4;

  // control-half address map
  localparam logic [ADDR_W-1:0] A_CMD  = 4'd8;
  localparam logic [ADDR_W-1:0] A_REQ  = 4'd9;
  localparam logic [ADDR_W-1:0] A_MSK  = 4'd10;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd11;
  localparam logic [ADDR_W-1:0] A_PCLR = 4'd12;
  localparam logic [ADDR_W-1:0] A_PSET = 4'd13;
  localparam logic [ADDR_W-1:0] A_MCLR = 4'd14;
  localparam logic [ADDR_W-1:0] A_MALL = 4'd15;

  typedef struct packed {
    logic wr_cmd;
    logic wr_req;
    logic wr_msk;
    logic wr_mode;
    logic wr_pclr;
    logic wr_pset;
    logic wr_mclr;
    logic wr_mall;
    logic rd_stat;
    logic rd_mode;
    logic rd_mcclr;
  } ctl_ev_t;
endpackage

// File: rtl/dma_acc_decode.sv
module dma_acc_decode
  import dma_prog_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          ior_ni,
  input  logic          iow_ni,
  input  logic          hold_ack_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_ev_o,
  output logic          wr_ev_o,
  output logic          chan_acc_o,
  output ctl_ev_t       ev_o
);
  logic ior_q, iow_q;
  logic prog_cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ior_q <= 1'b1;
      iow_q <= 1'b1;
    end else begin
      ior_q <= ior_ni;
      iow_q <= iow_ni;
    end
  end

  assign prog_cond  = !cs_ni && !hold_ack_i;
  // both strobes low at once is not a legal access
  assign rd_ev_o    = prog_cond && ior_q && !ior_ni && iow_ni;
  assign wr_ev_o    = prog_cond && iow_q && !iow_ni && ior_ni;
  assign chan_acc_o = !addr_i[AW-1];

  always_comb begin
    ev_o = '0;
    if (wr_ev_o && addr_i[AW-1]) begin
      case (addr_i)
        A_CMD:   ev_o.wr_cmd  = 1'b1;
        A_REQ:   ev_o.wr_req  = 1'b1;
        A_MSK:   ev_o.wr_msk  = 1'b1;
        A_MODE:  ev_o.wr_mode = 1'b1;
        A_PCLR:  ev_o.wr_pclr = 1'b1;
        A_PSET:  ev_o.wr_pset = 1'b1;
        A_MCLR:  ev_o.wr_mclr = 1'b1;
        default: ev_o.wr_mall = 1'b1;
      endcase
    end
    if (rd_ev_o && addr_i[AW-1]) begin
      case (addr_i)
        A_CMD:   ev_o.rd_stat  = 1'b1;
        A_MODE:  ev_o.rd_mode  = 1'b1;
        A_MCLR:  ev_o.rd_mcclr = 1'b1;
        default: ;
      endcase
    end
  end

  p_wr_one_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ev_o |=> !wr_ev_o);
  p_rd_one_shot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ev_o |=> !rd_ev_o);
  p_ev_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ev_o));
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  input  logic clr_i,
  input  logic set_i,
  output logic ptr_o
);
  logic ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= 1'b0;
    else if (clr_i)    ptr_q <= 1'b0;
    else if (set_i)    ptr_q <= 1'b1;
    else if (toggle_i) ptr_q <= !ptr_q;
  end

  assign ptr_o = ptr_q;

  p_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_i && !clr_i && !set_i) |=> (ptr_o != $past(ptr_o)));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!toggle_i && !clr_i && !set_i) |=> $stable(ptr_o));
  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ptr_o);
  p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> ptr_o);
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_prog_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int BW  = BYTE_W,
  parameter int CW  = CH_W,
  parameter int MW  = MODE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_ev_t         ev_i,
  input  logic [BW-1:0]   wdata_i,
  input  logic [NCH-1:0]  tc_i,
  input  logic [NCH-1:0]  dreq_i,
  output logic [BW-1:0]   cmd_o,
  output logic [NCH-1:0]  mask_o,
  output logic [NCH-1:0]  req_o,
  output logic [NCH*MW-1:0] mode_o,
  output logic [BW-1:0]   status_o,
  output logic [BW-1:0]   mode_rd_o,
  output logic            mclr_o
);
  logic [BW-1:0]  cmd_q;
  logic [NCH-1:0] mask_q, req_q, tc_q;
  logic [CW-1:0]  mcnt_q;
  logic           mclr_q;
  logic [MW-1:0]  mode_q [NCH];
  logic [CW-1:0]  wch;
  logic           wbit;
  logic           tc_clr;

  assign wch    = wdata_i[CW-1:0];
  assign wbit   = wdata_i[CW];
  assign tc_clr = ev_i.rd_stat || ev_i.wr_mclr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      mask_q <= '1;
      req_q  <= '0;
      mcnt_q <= '0;
      mclr_q <= 1'b0;
    end else begin
      mclr_q <= ev_i.wr_mclr;
      if (ev_i.wr_mclr) begin
        cmd_q  <= '0;
        mask_q <= '1;
        req_q  <= '0;
        mcnt_q <= '0;
      end else begin
        if (ev_i.wr_cmd)  cmd_q <= wdata_i;
        if (ev_i.wr_req)  req_q[wch] <= wbit;
        if (ev_i.wr_msk)       mask_q[wch] <= wbit;
        else if (ev_i.wr_mall) mask_q <= '0;
        if (ev_i.rd_mode)       mcnt_q <= mcnt_q + 1'b1;
        else if (ev_i.rd_mcclr) mcnt_q <= '0;
      end
    end
  end

  // set beats the read-side clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tc_q <= '0;
    else         tc_q <= (tc_clr ? '0 : tc_q) | tc_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mode_q[c] <= '0;
      else if (ev_i.wr_mode && wch == CW'(c))
        mode_q[c] <= wdata_i[BW-1:CW];
    end
    assign mode_o[c*MW +: MW] = mode_q[c];
  end

  assign cmd_o     = cmd_q;
  assign mask_o    = mask_q;
  assign req_o     = req_q;
  assign mclr_o    = mclr_q;
  assign status_o  = BW'({dreq_i, tc_q});
  assign mode_rd_o = {mode_q[mcnt_q], mcnt_q};

  p_mclr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.wr_mclr |=> (mask_o == '1 && cmd_o == '0 && req_o == '0 && mcnt_q == '0
                      && mclr_o && (tc_q & ~$past(tc_i)) == '0));
  p_mode_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.wr_mclr |=> $stable(mode_o));
  p_tc_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_i) |=> ((tc_q & $past(tc_i)) == $past(tc_i)));
  p_tc_rdclr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.rd_stat |=> ((tc_q & ~$past(tc_i)) == '0));
  p_mode_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.rd_mode |=> (mcnt_q == $past(mcnt_q) + 1'b1));
  p_mall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.wr_mall |=> (mask_o == '0));
endmodule

// File: rtl/dma_prog_port.sv
module dma_prog_port
  import dma_prog_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int BW  = BYTE_W,
  parameter int WW  = WORD_W,
  parameter int AW  = ADDR_W,
  parameter int CW  = CH_W,
  parameter int MW  = MODE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               ior_ni,
  input  logic               iow_ni,
  input  logic               hold_ack_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [BW-1:0]      data_i,
  input  logic [NCH*WW-1:0]  cur_addr_i,
  input  logic [NCH*WW-1:0]  cur_cnt_i,
  input  logic [NCH-1:0]     tc_i,
  input  logic [NCH-1:0]     dreq_i,
  output logic [BW-1:0]      data_o,
  output logic [NCH-1:0]     addr_we_o,
  output logic [NCH-1:0]     cnt_we_o,
  output logic               byte_hi_o,
  output logic [BW-1:0]      wdata_o,
  output logic [BW-1:0]      cmd_o,
  output logic [NCH-1:0]     mask_o,
  output logic [NCH-1:0]     req_o,
  output logic [NCH*MW-1:0]  mode_o,
  output logic               mclr_o
);
  logic          rd_ev, wr_ev, chan_acc, ptr;
  ctl_ev_t       ev;
  logic [BW-1:0] status, mode_rd, rd_mux, chan_byte;
  logic [WW-1:0] chan_word;
  logic [CW-1:0] ch_sel;
  logic [NCH-1:0] a_hit, c_hit;
  logic [NCH-1:0] addr_we_q, cnt_we_q;
  logic          byte_hi_q;
  logic [BW-1:0] wdata_q, rdata_q;

  dma_acc_decode #(.AW(AW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .ior_ni     (ior_ni),
    .iow_ni     (iow_ni),
    .hold_ack_i (hold_ack_i),
    .addr_i     (addr_i),
    .rd_ev_o    (rd_ev),
    .wr_ev_o    (wr_ev),
    .chan_acc_o (chan_acc),
    .ev_o       (ev)
  );

  dma_byte_ptr u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .toggle_i ((rd_ev || wr_ev) && chan_acc),
    .clr_i    (ev.wr_pclr || ev.wr_mclr),
    .set_i    (ev.wr_pset),
    .ptr_o    (ptr)
  );

  dma_ctrl_regs #(.NCH(NCH), .BW(BW), .CW(CW), .MW(MW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ev_i      (ev),
    .wdata_i   (data_i),
    .tc_i      (tc_i),
    .dreq_i    (dreq_i),
    .cmd_o     (cmd_o),
    .mask_o    (mask_o),
    .req_o     (req_o),
    .mode_o    (mode_o),
    .status_o  (status),
    .mode_rd_o (mode_rd),
    .mclr_o    (mclr_o)
  );

  assign ch_sel = addr_i[CW:1];

  for (genvar c = 0; c < NCH; c++) begin : g_we
    assign a_hit[c] = wr_ev && chan_acc && !addr_i[0] && ch_sel == CW'(c);
    assign c_hit[c] = wr_ev && chan_acc &&  addr_i[0] && ch_sel == CW'(c);
  end

  always_comb begin
    chan_word = addr_i[0] ? cur_cnt_i[ch_sel*WW +: WW] : cur_addr_i[ch_sel*WW +: WW];
    chan_byte = ptr ? chan_word[WW-1:BW] : chan_word[BW-1:0];
    if (chan_acc) begin
      rd_mux = chan_byte;
    end else begin
      case (addr_i)
        A_CMD:   rd_mux = status;
        A_REQ:   rd_mux = BW'(req_o);
        A_MSK:   rd_mux = BW'(mask_o);
        A_MODE:  rd_mux = mode_rd;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_we_q <= '0;
      cnt_we_q  <= '0;
      byte_hi_q <= 1'b0;
      wdata_q   <= '0;
      rdata_q   <= '0;
    end else begin
      addr_we_q <= a_hit;
      cnt_we_q  <= c_hit;
      if (wr_ev && chan_acc) begin
        byte_hi_q <= ptr;
        wdata_q   <= data_i;
      end
      if (rd_ev) rdata_q <= rd_mux;
    end
  end

  assign addr_we_o = addr_we_q;
  assign cnt_we_o  = cnt_we_q;
  assign byte_hi_o = byte_hi_q;
  assign wdata_o   = wdata_q;
  assign data_o    = rdata_q;

  p_locked_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || hold_ack_i) |=> ($stable(cmd_o) && $stable(mask_o) && $stable(req_o)
                               && $stable(mode_o) && !mclr_o
                               && addr_we_o == '0 && cnt_we_o == '0));
  p_we_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({addr_we_o, cnt_we_o}));
  p_we_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{addr_we_o, cnt_we_o}) |=> !(|{addr_we_o, cnt_we_o}));
  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ior_ni |=> $stable(data_o));
endmodule

// File: tb/tb_dma_prog_port.sv
`timescale 1ns/1ps
module tb_dma_prog_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1, hold_ack = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  din = '0;
  logic [63:0] cur_addr, cur_cnt;
  logic [3:0]  tc_in = '0, dreq = '0;
  logic [7:0]  data_o, wdata_o, cmd_o;
  logic [3:0]  addr_we_o, cnt_we_o, mask_o, req_o;
  logic [23:0] mode_o;
  logic        byte_hi_o, mclr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0] cap_awe, cap_cwe;
  logic       cap_hi, cap_mclr;
  logic [7:0] cap_wd, cap_rd;
  int         pulses;

  always #4 clk = ~clk;

  dma_prog_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ior_ni(ior_n), .iow_ni(iow_n),
    .hold_ack_i(hold_ack), .addr_i(addr), .data_i(din),
    .cur_addr_i(cur_addr), .cur_cnt_i(cur_cnt), .tc_i(tc_in), .dreq_i(dreq),
    .data_o(data_o), .addr_we_o(addr_we_o), .cnt_we_o(cnt_we_o),
    .byte_hi_o(byte_hi_o), .wdata_o(wdata_o), .cmd_o(cmd_o), .mask_o(mask_o),
    .req_o(req_o), .mode_o(mode_o), .mclr_o(mclr_o)
  );

  initial begin
    for (int c = 0; c < 4; c++) begin
      cur_addr[c*16 +: 16] = {8'hA0 + 8'(c), 8'h10 + 8'(c)};
      cur_cnt[c*16 +: 16]  = {8'hC0 + 8'(c), 8'h20 + 8'(c)};
    end
  end

  // {wr, addr, data, expected read, requirement}
  localparam int NV = 31;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 4'd8,  8'h00, 8'h00, 4'd12}, // R12 status after reset
    {1'b0, 4'd10, 8'h00, 8'h0F, 4'd12}, // R12 mask after reset
    {1'b1, 4'd10, 8'h01, 8'h00, 4'd8},  // R8 clear mask ch1
    {1'b0, 4'd10, 8'h00, 8'h0D, 4'd8},
    {1'b1, 4'd9,  8'h06, 8'h00, 4'd8},  // R8 set request ch2
    {1'b0, 4'd9,  8'h00, 8'h04, 4'd8},
    {1'b1, 4'd11, 8'hB7, 8'h00, 4'd9},  // R9 mode ch3
    {1'b1, 4'd11, 8'h48, 8'h00, 4'd9},  // R9 mode ch0
    {1'b0, 4'd11, 8'h00, 8'h48, 4'd9},
    {1'b0, 4'd11, 8'h00, 8'h01, 4'd9},
    {1'b0, 4'd11, 8'h00, 8'h02, 4'd9},
    {1'b0, 4'd11, 8'h00, 8'hB7, 4'd9},
    {1'b0, 4'd11, 8'h00, 8'h48, 4'd9},  // counter wraps
    {1'b0, 4'd14, 8'h00, 8'h00, 4'd9},  // rewind mode counter
    {1'b0, 4'd11, 8'h00, 8'h48, 4'd9},
    {1'b0, 4'd2,  8'h00, 8'h11, 4'd6},  // R6 ch1 address low
    {1'b0, 4'd2,  8'h00, 8'hA1, 4'd4},  // R4 pointer flipped
    {1'b0, 4'd5,  8'h00, 8'h22, 4'd6},
    {1'b1, 4'd12, 8'hFF, 8'h00, 4'd5},  // R5 clear pointer
    {1'b0, 4'd5,  8'h00, 8'h22, 4'd5},
    {1'b1, 4'd13, 8'h00, 8'h00, 4'd5},  // R5 set pointer
    {1'b0, 4'd7,  8'h00, 8'hC3, 4'd5},
    {1'b0, 4'd0,  8'h00, 8'h10, 4'd4},
    {1'b1, 4'd15, 8'hAA, 8'h00, 4'd11}, // R11 clear all masks
    {1'b0, 4'd10, 8'h00, 8'h00, 4'd11},
    {1'b1, 4'd10, 8'h07, 8'h00, 4'd8},
    {1'b0, 4'd10, 8'h00, 8'h08, 4'd8},
    {1'b1, 4'd14, 8'h00, 8'h00, 4'd10}, // R10 master clear
    {1'b0, 4'd10, 8'h00, 8'h0F, 4'd10},
    {1'b0, 4'd9,  8'h00, 8'h00, 4'd10},
    {1'b0, 4'd11, 8'h00, 8'h48, 4'd10}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [3:0] a, input logic [7:0] d,
                     input int hold, input logic cs_off, input logic [3:0] tc);
    @(negedge clk);
    addr = a; din = d; cs_n = cs_off; tc_in = tc;
    if (wr) iow_n = 1'b0; else ior_n = 1'b0;
    @(negedge clk);
    tc_in = '0;
    cap_awe = addr_we_o; cap_cwe = cnt_we_o; cap_hi = byte_hi_o;
    cap_wd = wdata_o; cap_mclr = mclr_o; cap_rd = data_o;
    pulses = $countones({addr_we_o, cnt_we_o});
    for (int i = 1; i < hold; i++) begin
      @(negedge clk);
      pulses += $countones({addr_we_o, cnt_we_o});
    end
    iow_n = 1'b1; ior_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 cmd", 32'(cmd_o), 32'h00);
    chk("R12 mask", 32'(mask_o), 32'h0F);
    chk("R12 req", 32'(req_o), 32'h0);
    chk("R12 mode", 32'(mode_o), 32'h0);
    chk("R12 data", 32'(data_o), 32'h0);
    chk("R12 pulses", 32'({addr_we_o, cnt_we_o, mclr_o}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      acc(v[24], v[23:20], v[19:12], 1, 1'b0, 4'h0);
      if (!v[24]) chk($sformatf("R%0d vec%0d", v[3:0], i), 32'(cap_rd), 32'(v[11:4]));
    end

    // R3 count-register write, low then high byte
    acc(1'b1, 4'd3, 8'h34, 1, 1'b0, 4'h0);
    chk("R3 cnt_we", 32'({cap_awe, cap_cwe}), 32'h02);
    chk("R3 wdata", 32'(cap_wd), 32'h34);
    chk("R3 byte lo", 32'(cap_hi), 32'h0);
    acc(1'b1, 4'd3, 8'h12, 1, 1'b0, 4'h0);
    chk("R3 byte hi", 32'({cap_hi, cap_wd}), 32'h112);
    chk("R3 pulse ends", 32'({addr_we_o, cnt_we_o}), 32'h0);
    acc(1'b1, 4'd0, 8'h55, 1, 1'b0, 4'h0);
    chk("R3 addr_we", 32'({cap_awe, cap_cwe, cap_hi}), 32'h020);

    // R1 locked while hold acknowledged or deselected
    hold_ack = 1'b1;
    acc(1'b1, 4'd8, 8'h77, 1, 1'b0, 4'h0);
    chk("R1 cmd kept", 32'(cmd_o), 32'h00);
    acc(1'b1, 4'd0, 8'h66, 1, 1'b0, 4'h0);
    chk("R1 no we hold", 32'({cap_awe, cap_cwe}), 32'h0);
    hold_ack = 1'b0;
    acc(1'b1, 4'd15, 8'h00, 1, 1'b1, 4'h0);
    chk("R1 mask kept cs", 32'(mask_o), 32'h0F);
    acc(1'b1, 4'd0, 8'h66, 1, 1'b0, 4'h0);
    chk("R1 pointer kept", 32'(cap_hi), 32'h1);

    // R2 held strobe gives one access
    acc(1'b1, 4'd0, 8'h99, 4, 1'b0, 4'h0);
    chk("R2 one pulse", 32'(pulses), 32'd1);
    acc(1'b1, 4'd1, 8'h98, 1, 1'b0, 4'h0);
    chk("R2 one flip", 32'({cap_cwe, cap_hi}), 32'h03);

    // R7 status and terminal count
    dreq = 4'hA;
    @(negedge clk); tc_in = 4'b0101;
    @(negedge clk); tc_in = 4'b0000;
    acc(1'b0, 4'd8, 8'h00, 1, 1'b0, 4'h0);
    chk("R7 status", 32'(cap_rd), 32'hA5);
    acc(1'b0, 4'd8, 8'h00, 1, 1'b0, 4'h0);
    chk("R7 read clears", 32'(cap_rd), 32'hA0);
    acc(1'b0, 4'd8, 8'h00, 1, 1'b0, 4'b0010);
    chk("R7 same-cycle read", 32'(cap_rd), 32'hA0);
    acc(1'b0, 4'd8, 8'h00, 1, 1'b0, 4'h0);
    chk("R7 set wins", 32'(cap_rd), 32'hA2);
    acc(1'b1, 4'd8, 8'h5A, 1, 1'b0, 4'h0);
    chk("R7 cmd load", 32'(cmd_o), 32'h5A);

    // R10 master clear with data ignored
    @(negedge clk); tc_in = 4'b1000;
    @(negedge clk); tc_in = 4'b0000;
    acc(1'b1, 4'd14, 8'hFF, 1, 1'b0, 4'h0);
    chk("R10 pulse", 32'(cap_mclr), 32'h1);
    chk("R10 regs", 32'({cmd_o, mask_o, req_o}), 32'h00F0);
    chk("R10 modes kept", 32'(mode_o), 32'({6'h2D, 6'h00, 6'h00, 6'h12}));
    acc(1'b0, 4'd8, 8'h00, 1, 1'b0, 4'h0);
    chk("R10 tc cleared", 32'(cap_rd), 32'hA0);
    acc(1'b0, 4'd6, 8'h00, 1, 1'b0, 4'h0);
    chk("R10 pointer cleared", 32'(cap_rd), 32'h13);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule